// File: doc/BRIEF.md
# Interrupt Cause Register Array with Self-Masking Vectors

This block keeps an 8-bit cause register for every interrupt vector. Several event sources can share one vector, so the block decides whether an event may turn into a message request. An event source presents a vector number and a non-zero cause code. A register that holds zero marks its vector as armed. When an event reaches an armed vector, the block stores the cause in that register and raises a one-cycle message request on that vector's line. Because the register is now non-zero, the vector is masked. No separate mask bit exists: the stored cause is the mask.

The host reaches the registers over a simple byte-addressed register bus. Each register sits at a base offset plus its vector index. The host reads the register to learn the cause, then writes zero to arm the vector again. A bypass control turns off the self-masking scheme: while it is high, every valid event becomes a request at once and the registers are not touched. The cause codes in use are 1 for ring receive or transmit activity and 2 for a link state change. Other non-zero values are stored as given.

Top module: `irq_cause_mask`

## Requirements
- R1: After reset every cause register reads 0, `msgReq` is all zero and `regRdValid` is low.
- R2: With `bypassEn` low, a valid event with a non-zero cause for a vector whose register is 0 stores the cause in that register. It also sets `msgReq[vector]` in the cycle after the event.
- R3: With `bypassEn` low, an event for a vector whose register is non-zero raises no request and leaves the stored value unchanged.
- R4: A host write of 0 to a vector's register arms that vector again, so the next event for it is accepted.
- R5: A read with `regRdEn` returns the register at byte address `BASE_ADDR + index` on `regRdData`, with `regRdValid` high, exactly one cycle later. A read outside the window `BASE_ADDR` to `BASE_ADDR + 63` returns 0, and a write outside that window changes no register.
- R6: When a host write of 0 and an event target the same vector in the same cycle, the event wins: the new cause is stored and a request is issued.
- R7: With `bypassEn` high, every valid event with a non-zero cause raises `msgReq[vector]` one cycle later, whatever the register holds, and the register is left unchanged.
- R8: An event with cause code 0 is ignored: no request and no register change.
- R9: `msgReq` never has more than one bit set, each request lasts exactly one cycle, and no request appears in a cycle that does not follow a valid event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| bypassEn | input | 1 | High: events pass straight to requests, registers untouched |
| evtValid | input | 1 | Event present this cycle |
| evtVector | input | 6 | Vector index of the event |
| evtCause | input | 8 | Cause code of the event (1 ring activity, 2 link change) |
| regWrEn | input | 1 | Host write strobe |
| regRdEn | input | 1 | Host read strobe |
| regAddr | input | 16 | Host byte address |
| regWrData | input | 8 | Host write data |
| regRdData | output | 8 | Read data, valid with `regRdValid` |
| regRdValid | output | 1 | Read data valid, one cycle after `regRdEn` |
| msgReq | output | 64 | One-cycle message request, one bit per vector |

## Verification
An event presented before a clock edge updates the register at that edge and shows its request on `msgReq` in the following cycle. The bench samples `msgReq` at the falling edge after that rising edge, then samples it again one cycle later to confirm the pulse has ended. Read data arrives one cycle after the read strobe. Each read pushes its expected byte into a queue, and a monitor pops that byte at the falling edge where `regRdValid` is high, so every comparison lands in the cycle the result is due. A register change caused by an event or a write is observed through a read issued after that edge.

// File: rtl/irq_cause_pkg.sv
package irq_cause_pkg;
  parameter int VEC_NUM = 64;
  parameter int CAUSE_W = 8;
  localparam int IDX_W = $clog2(VEC_NUM);

  typedef enum logic [CAUSE_W-1:0] {
    CAUSE_NONE = 8'd0,
    CAUSE_RING = 8'd1,
    CAUSE_LINK = 8'd2
  } cause_e;

  // strobes from control to datapath
  typedef struct packed {
    logic               hostWr;
    logic [IDX_W-1:0]   hostIdx;
    logic [CAUSE_W-1:0] hostData;
    logic               evtStore;
    logic               evtReq;
    logic [IDX_W-1:0]   evtIdx;
    logic [CAUSE_W-1:0] evtCause;
    logic               rdEn;
    logic               rdHit;
    logic [IDX_W-1:0]   rdIdx;
  } strobe_t;
endpackage

// File: rtl/irq_cause_ctrl.sv
module irq_cause_ctrl
  import irq_cause_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0C00
) (
  input  logic                bypassEn,
  input  logic                evtValid,
  input  logic [IDX_W-1:0]    evtVector,
  input  logic [CAUSE_W-1:0]  evtCause,
  input  logic [CAUSE_W-1:0]  curCause,
  input  logic                regWrEn,
  input  logic                regRdEn,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic [CAUSE_W-1:0]  regWrData,
  output strobe_t             st
);
  localparam logic [ADDR_W-1:0] WIN_SIZE = ADDR_W'(VEC_NUM);

  logic [ADDR_W-1:0] offset;
  logic              inWin;
  logic              evtOk;
  logic              clearSame;
  logic              armed;

  assign offset = regAddr - BASE_ADDR;
  assign inWin  = (regAddr >= BASE_ADDR) && (offset < WIN_SIZE);
  assign evtOk  = evtValid && (evtCause != CAUSE_NONE);

  // a host clear of the same vector in this cycle re-arms it for the event
  assign clearSame = regWrEn && inWin && (offset[IDX_W-1:0] == evtVector)
                     && (regWrData == '0);
  assign armed = (curCause == '0) || clearSame;

  always_comb begin
    st          = '0;
    st.hostWr   = regWrEn && inWin;
    st.hostIdx  = offset[IDX_W-1:0];
    st.hostData = regWrData;
    st.evtIdx   = evtVector;
    st.evtCause = evtCause;
    st.rdEn     = regRdEn;
    st.rdHit    = regRdEn && inWin;
    st.rdIdx    = offset[IDX_W-1:0];
    if (bypassEn) begin
      st.evtStore = 1'b0;
      st.evtReq   = evtOk;
    end else begin
      st.evtStore = evtOk && armed;
      st.evtReq   = evtOk && armed;
    end
  end
endmodule

// File: rtl/irq_cause_dp.sv
module irq_cause_dp
  import irq_cause_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            st,
  input  logic [IDX_W-1:0]   lookIdx,
  output logic [CAUSE_W-1:0] lookCause,
  output logic [CAUSE_W-1:0] rdData,
  output logic               rdValid,
  output logic [VEC_NUM-1:0] msgReq
);
  logic [VEC_NUM-1:0][CAUSE_W-1:0] causeAll;

  for (genvar v = 0; v < VEC_NUM; v++) begin : g_slot
    logic [CAUSE_W-1:0] slotQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        slotQ <= '0;
      end else if (st.evtStore && (st.evtIdx == IDX_W'(v))) begin
        slotQ <= st.evtCause;
      end else if (st.hostWr && (st.hostIdx == IDX_W'(v))) begin
        slotQ <= st.hostData;
      end
    end
    assign causeAll[v] = slotQ;
  end

  assign lookCause = causeAll[lookIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdData  <= '0;
      rdValid <= 1'b0;
      msgReq  <= '0;
    end else begin
      rdValid <= st.rdEn;
      rdData  <= st.rdHit ? causeAll[st.rdIdx] : '0;
      msgReq  <= st.evtReq ? (VEC_NUM'(1) << st.evtIdx) : '0;
    end
  end
endmodule

// File: rtl/irq_cause_mask.sv
module irq_cause_mask
  import irq_cause_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0C00
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               bypassEn,
  input  logic               evtValid,
  input  logic [IDX_W-1:0]   evtVector,
  input  logic [CAUSE_W-1:0] evtCause,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [CAUSE_W-1:0] regWrData,
  output logic [CAUSE_W-1:0] regRdData,
  output logic               regRdValid,
  output logic [VEC_NUM-1:0] msgReq
);
  strobe_t            st;
  logic [CAUSE_W-1:0] curCause;

  irq_cause_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) ctrlI (
    .bypassEn (bypassEn),
    .evtValid (evtValid),
    .evtVector(evtVector),
    .evtCause (evtCause),
    .curCause (curCause),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .regAddr  (regAddr),
    .regWrData(regWrData),
    .st       (st)
  );

  irq_cause_dp dpI (
    .clk      (clk),
    .rstN     (rstN),
    .st       (st),
    .lookIdx  (evtVector),
    .lookCause(curCause),
    .rdData   (regRdData),
    .rdValid  (regRdValid),
    .msgReq   (msgReq)
  );
endmodule

// File: rtl/irq_cause_chk.sv
module irq_cause_chk
  import irq_cause_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               bypassEn,
  input logic               evtValid,
  input logic [IDX_W-1:0]   evtVector,
  input logic [CAUSE_W-1:0] evtCause,
  input logic               regRdEn,
  input logic               regRdValid,
  input logic [VEC_NUM-1:0] msgReq
);
  logic [IDX_W-1:0] evtVecQ;
  always_ff @(posedge clk) evtVecQ <= evtVector;

  // R9
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(msgReq));

  // R9
  req_needs_evt_chk: assert property (@(posedge clk) disable iff (!rstN)
    !evtValid |=> (msgReq == '0));

  // R5
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rstN)
    regRdEn |=> regRdValid);

  // R5
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> !regRdValid);

  // R7
  bypass_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bypassEn && evtValid && (evtCause != '0)) |=> msgReq[evtVecQ]);

  // R8
  zero_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && (evtCause == '0)) |=> (msgReq == '0));
endmodule

bind irq_cause_mask irq_cause_chk chkI (
  .clk       (clk),
  .rstN      (rstN),
  .bypassEn  (bypassEn),
  .evtValid  (evtValid),
  .evtVector (evtVector),
  .evtCause  (evtCause),
  .regRdEn   (regRdEn),
  .regRdValid(regRdValid),
  .msgReq    (msgReq)
);

// File: tb/irq_cause_mask_test.sv
module irq_cause_mask_test;
  localparam int VN = 64;
  localparam logic [15:0] BASE = 16'h0C00;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        bypassEn = 1'b0;
  logic        evtValid = 1'b0;
  logic [5:0]  evtVector = '0;
  logic [7:0]  evtCause = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [15:0] regAddr = '0;
  logic [7:0]  regWrData = '0;
  logic [7:0]  regRdData;
  logic        regRdValid;
  logic [VN-1:0] msgReq;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  logic [7:0] expQ [$];
  string      tagQ [$];

  always #2 clk = ~clk;

  irq_cause_mask uut (
    .clk(clk), .rstN(rstN), .bypassEn(bypassEn),
    .evtValid(evtValid), .evtVector(evtVector), .evtCause(evtCause),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .regRdValid(regRdValid), .msgReq(msgReq)
  );

  task automatic check(input bit ok, input string tag,
                       input logic [VN-1:0] act, input logic [VN-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data when a result appears
  always @(negedge clk) begin
    if (rstN && regRdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R5 unexpected read data", VN'(regRdData), '0);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(regRdData == e, t, VN'(regRdData), VN'(e));
      end
    end
  end

  task automatic hostRd(input logic [15:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    expQ.push_back(e); tagQ.push_back(t);
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic hostWr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  // drive event (optionally with a same-cycle host write), check request pulse
  task automatic postEvt(input logic [5:0] v, input logic [7:0] c, input bit expReq,
                         input bit withWr, input logic [15:0] wa,
                         input logic [7:0] wd, input string t);
    logic [VN-1:0] e;
    @(negedge clk);
    evtValid = 1'b1; evtVector = v; evtCause = c;
    if (withWr) begin regWrEn = 1'b1; regAddr = wa; regWrData = wd; end
    @(negedge clk);
    evtValid = 1'b0; regWrEn = 1'b0;
    e = expReq ? (VN'(1) << v) : '0;
    check(msgReq == e, t, msgReq, e);
    @(negedge clk);
    check(msgReq == '0, "R9 request lasts one cycle", msgReq, '0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(msgReq == '0, "R1 msgReq at reset", msgReq, '0);
    check(regRdValid == 1'b0, "R1 regRdValid at reset", VN'(regRdValid), '0);
    rstN = 1'b1;
    hostRd(BASE, 8'd0, "R1 reg0 after reset");
    hostRd(BASE + 16'd63, 8'd0, "R1 reg63 after reset");

    // R2 accepted events
    postEvt(6'd5, 8'd1, 1'b1, 1'b0, '0, '0, "R2 request vec5");
    hostRd(BASE + 16'd5, 8'd1, "R2 cause stored vec5");
    postEvt(6'd63, 8'd2, 1'b1, 1'b0, '0, '0, "R2 request vec63");
    hostRd(BASE + 16'd63, 8'd2, "R2 cause stored vec63");

    // R3 masked vector
    postEvt(6'd5, 8'd2, 1'b0, 1'b0, '0, '0, "R3 no request when masked");
    hostRd(BASE + 16'd5, 8'd1, "R3 cause unchanged");
    hostWr(BASE + 16'd10, 8'd3);
    hostRd(BASE + 16'd10, 8'd3, "R3 host-set value");
    postEvt(6'd10, 8'd1, 1'b0, 1'b0, '0, '0, "R3 host-masked vector");
    hostRd(BASE + 16'd10, 8'd3, "R3 host value kept");

    // R4 re-arm
    hostWr(BASE + 16'd5, 8'd0);
    hostRd(BASE + 16'd5, 8'd0, "R4 cleared");
    postEvt(6'd5, 8'd2, 1'b1, 1'b0, '0, '0, "R4 request after clear");
    hostRd(BASE + 16'd5, 8'd2, "R4 new cause");

    // R5 address window
    hostRd(BASE + 16'd64, 8'd0, "R5 read above window");
    hostRd(BASE - 16'd1, 8'd0, "R5 read below window");
    hostWr(BASE - 16'd1, 8'h77);
    hostWr(BASE + 16'd64, 8'h55);
    hostRd(BASE, 8'd0, "R5 out-of-window write left reg0");
    hostRd(BASE + 16'd63, 8'd2, "R5 out-of-window write left reg63");

    // R6 clear and event on the same vector and cycle
    postEvt(6'd5, 8'd1, 1'b1, 1'b1, BASE + 16'd5, 8'd0, "R6 event wins request");
    hostRd(BASE + 16'd5, 8'd1, "R6 event cause stored");

    // R8 zero cause
    postEvt(6'd7, 8'd0, 1'b0, 1'b0, '0, '0, "R8 zero cause no request");
    hostRd(BASE + 16'd7, 8'd0, "R8 register untouched");

    // R7 bypass
    bypassEn = 1'b1;
    postEvt(6'd5, 8'd2, 1'b1, 1'b0, '0, '0, "R7 bypass on masked vector");
    hostRd(BASE + 16'd5, 8'd1, "R7 masked register unchanged");
    postEvt(6'd7, 8'd1, 1'b1, 1'b0, '0, '0, "R7 bypass on armed vector");
    hostRd(BASE + 16'd7, 8'd0, "R7 armed register unchanged");
    bypassEn = 1'b0;

    repeat (3) @(negedge clk);
    check(expQ.size() == 0, "R5 all reads returned", VN'(expQ.size()), '0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule